// File: doc/BRIEF.md
# Sequential Block Prefetch Controller

This unit sits beside a small direct-mapped cache and decides when to ask the memory side for the block that follows the one being accessed. Each cycle it sees at most one demand access, given as a block address and whether the access hit. If its policy allows, it queues a request for block b+1. It also sees at most one fill completion, given as the cache line that was written and whether the data came from a prefetch or from a demand miss.

A two-bit policy input picks the rule. In lookahead mode every access triggers. In miss mode only misses trigger. In tagged mode a prefetch goes out on a miss, or on the first hit to a block that arrived by prefetch. A per-line marker bit records that a block was prefetched and has not been referenced yet. A fourth code turns request generation off and leaves the marker bits working.

Requests wait in one output slot under a valid/ready handshake. A newer request overwrites one that has not yet been taken.

Top module: `obl_prefetcher`

## Requirements
- R1: After reset, `pf_valid_o` is 0 and every bit of `tag_bits_o` is 0.
- R2: With `mode_i` = 0 (lookahead), an access to block b with b not all ones makes `pf_valid_o` 1 with `pf_blk_o` = b+1 on the next cycle, whether the access hit or missed.
- R3: With `mode_i` = 1 (miss only), an access that misses triggers a request for b+1. An access that hits triggers nothing.
- R4: With `mode_i` = 2 (tagged), a request for b+1 is triggered by a miss, or by a hit whose line marker bit is 1. A hit whose marker bit is 0 triggers nothing.
- R5: A fill writes the marker bit of line `fill_line_i`: 1 for a prefetch fill (`fill_is_pf_i` = 1) and 0 for a demand fill. The line of block b is the low LINE_W bits of b.
- R6: In every mode, a hit clears the marker bit of the accessed line on the next cycle. A miss leaves that bit unchanged.
- R7: With `mode_i` = 3 (off), no request is ever triggered, and the marker bits are still updated as in R5 and R6.
- R8: An access to the all-ones block address never triggers a request, in any mode.
- R9: The request slot holds `pf_blk_o` stable while `pf_valid_o` is 1 and `pf_ready_i` is 0. It empties the cycle after a handshake unless a new trigger arrives. A new trigger always replaces the slot contents, even when they are still pending.
- R10: When a fill and a hit address the same line in the same cycle, the fill's value is written to the marker bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy: 0 lookahead, 1 miss only, 2 tagged, 3 off |
| acc_valid_i | input | 1 | Demand access present this cycle |
| acc_blk_i | input | ADDR_W | Block address of the demand access |
| acc_hit_i | input | 1 | Demand access hit in the cache |
| fill_valid_i | input | 1 | A fill completes this cycle |
| fill_line_i | input | LINE_W | Cache line written by the fill |
| fill_is_pf_i | input | 1 | Fill was a prefetch (1) or a demand fill (0) |
| pf_ready_i | input | 1 | Memory side accepts the pending request |
| pf_valid_o | output | 1 | A prefetch request is pending |
| pf_blk_o | output | ADDR_W | Block address of the pending request |
| tag_bits_o | output | 2**LINE_W | Per-line marker bits, bit i for line i |

## Verification
Contiguous streams are driven in all four policies. In each one the sequence is a miss, a prefetch fill of the next block, then a hit on that block. These streams separate the modes: lookahead and tagged modes issue on the stream hit, while miss-only mode stays silent there. Repeated hits to the same block test that tagged mode fires only on the first reference, and an access to the top block tests the overflow guard. Stalled handshakes with new accesses arriving test that pending requests are held and replaced. A fill that collides with a hit on the same line tests write priority. A long run of random accesses, fills and ready values over a narrow address range is then compared cycle by cycle against a behavioural model.

// File: rtl/obl_pf_pkg.sv
package obl_pf_pkg;
  typedef enum logic [1:0] {
    PF_LOOKAHEAD = 2'd0,
    PF_ON_MISS   = 2'd1,
    PF_TAGGED    = 2'd2,
    PF_OFF       = 2'd3
  } pf_mode_e;
endpackage

// File: rtl/obl_tag_array.sv
module obl_tag_array #(
  parameter int LINE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_en,
  input  logic [LINE_W-1:0]     clr_line,
  input  logic                  set_en,
  input  logic [LINE_W-1:0]     set_line,
  input  logic                  set_val,
  output logic [(1<<LINE_W)-1:0] bits_o
);
  localparam int LINES = 1 << LINE_W;

  // One flop per line; a fill has priority over a hit clear on the same line.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        bits_o[i] <= 1'b0;
      end else if (set_en && set_line == LINE_W'(i)) begin
        bits_o[i] <= set_val;
      end else if (clr_en && clr_line == LINE_W'(i)) begin
        bits_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/obl_trigger.sv
module obl_trigger
  import obl_pf_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_blk,
  input  logic              acc_hit,
  input  logic              line_tag,
  output logic              fire,
  output logic [ADDR_W-1:0] next_blk
);
  logic at_top;
  logic policy_ok;

  assign at_top   = &acc_blk;
  assign next_blk = acc_blk + ADDR_W'(1);

  always_comb begin
    unique case (pf_mode_e'(mode))
      PF_LOOKAHEAD: policy_ok = 1'b1;
      PF_ON_MISS:   policy_ok = !acc_hit;
      PF_TAGGED:    policy_ok = !acc_hit || line_tag;
      default:      policy_ok = 1'b0;
    endcase
  end

  assign fire = acc_valid && !at_top && policy_ok;
endmodule

// File: rtl/obl_req_slot.sv
module obl_req_slot #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_blk,
  input  logic              ready,
  output logic              valid_o,
  output logic [ADDR_W-1:0] blk_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      blk_o   <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      blk_o   <= load_blk;
    end else if (valid_o && ready) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/obl_prefetcher.sv
module obl_prefetcher #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode_i,
  input  logic                   acc_valid_i,
  input  logic [ADDR_W-1:0]      acc_blk_i,
  input  logic                   acc_hit_i,
  input  logic                   fill_valid_i,
  input  logic [LINE_W-1:0]      fill_line_i,
  input  logic                   fill_is_pf_i,
  input  logic                   pf_ready_i,
  output logic                   pf_valid_o,
  output logic [ADDR_W-1:0]      pf_blk_o,
  output logic [(1<<LINE_W)-1:0] tag_bits_o
);
  localparam int LINES = 1 << LINE_W;

  logic [LINE_W-1:0] acc_line;
  logic              acc_tag;
  logic              fire;
  logic [ADDR_W-1:0] next_blk;

  assign acc_line = acc_blk_i[LINE_W-1:0];
  assign acc_tag  = tag_bits_o[acc_line];

  obl_tag_array #(.LINE_W(LINE_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (acc_valid_i && acc_hit_i),
    .clr_line (acc_line),
    .set_en   (fill_valid_i),
    .set_line (fill_line_i),
    .set_val  (fill_is_pf_i),
    .bits_o   (tag_bits_o)
  );

  obl_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .mode      (mode_i),
    .acc_valid (acc_valid_i),
    .acc_blk   (acc_blk_i),
    .acc_hit   (acc_hit_i),
    .line_tag  (acc_tag),
    .fire      (fire),
    .next_blk  (next_blk)
  );

  obl_req_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (fire),
    .load_blk (next_blk),
    .ready    (pf_ready_i),
    .valid_o  (pf_valid_o),
    .blk_o    (pf_blk_o)
  );

  initial begin
    if (LINE_W > ADDR_W || LINES < 2) $error("obl_prefetcher: bad LINE_W");
  end
endmodule

// File: rtl/obl_prefetcher_chk.sv
module obl_prefetcher_chk #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             mode_i,
  input logic                   acc_valid_i,
  input logic [ADDR_W-1:0]      acc_blk_i,
  input logic                   acc_hit_i,
  input logic                   fill_valid_i,
  input logic [LINE_W-1:0]      fill_line_i,
  input logic                   fill_is_pf_i,
  input logic                   pf_ready_i,
  input logic                   pf_valid_o,
  input logic [ADDR_W-1:0]      pf_blk_o,
  input logic [(1<<LINE_W)-1:0] tag_bits_o
);
  logic stalled;
  logic not_top;
  assign stalled = pf_valid_o && !pf_ready_i;
  assign not_top = !(&acc_blk_i);

  assert_lookahead_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && mode_i == 2'd0 && not_top |=> pf_valid_o && pf_blk_o == $past(acc_blk_i) + ADDR_W'(1));

  assert_hit_silent_R3: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && mode_i == 2'd1 && acc_hit_i && !stalled |=> !pf_valid_o);

  assert_tag_zero_silent_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && mode_i == 2'd2 && acc_hit_i && !tag_bits_o[acc_blk_i[LINE_W-1:0]] && !stalled |=> !pf_valid_o);

  assert_tag_one_fires_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && mode_i == 2'd2 && acc_hit_i && tag_bits_o[acc_blk_i[LINE_W-1:0]] && not_top
    |=> pf_valid_o && pf_blk_o == $past(acc_blk_i) + ADDR_W'(1));

  assert_fill_write_R5: assert property (@(posedge clk) disable iff (rst)
    fill_valid_i |=> tag_bits_o[$past(fill_line_i)] == $past(fill_is_pf_i));

  assert_hit_clear_R6: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && acc_hit_i && !(fill_valid_i && fill_line_i == acc_blk_i[LINE_W-1:0])
    |=> !tag_bits_o[$past(acc_blk_i[LINE_W-1:0])]);

  assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
    mode_i == 2'd3 && !stalled |=> !pf_valid_o);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i && !not_top && !stalled |=> !pf_valid_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    stalled && !acc_valid_i |=> pf_valid_o && $stable(pf_blk_o));
endmodule

bind obl_prefetcher obl_prefetcher_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_obl_prefetcher.sv
module tb_obl_prefetcher;
  localparam int ADDR_W = 12;
  localparam int LINE_W = 4;
  localparam int LINES  = 1 << LINE_W;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        mode_i;
  logic              acc_valid_i;
  logic [ADDR_W-1:0] acc_blk_i;
  logic              acc_hit_i;
  logic              fill_valid_i;
  logic [LINE_W-1:0] fill_line_i;
  logic              fill_is_pf_i;
  logic              pf_ready_i;
  logic              pf_valid_o;
  logic [ADDR_W-1:0] pf_blk_o;
  logic [LINES-1:0]  tag_bits_o;

  int checks = 0;
  int errors = 0;
  bit compare_on = 1'b0;

  // behavioural reference
  bit          m_valid;
  int unsigned m_blk;
  bit          m_bits [LINES];

  always #5 clk = ~clk;

  obl_prefetcher #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned model_tags();
    int unsigned v = 0;
    for (int i = 0; i < LINES; i++) if (m_bits[i]) v |= (1 << i);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_blk   <= 0;
      for (int i = 0; i < LINES; i++) m_bits[i] <= 1'b0;
    end else begin
      int  line;
      bit  go;
      line = int'(acc_blk_i) % LINES;
      go = 1'b0;
      if (acc_valid_i && acc_blk_i != {ADDR_W{1'b1}}) begin
        if (mode_i == 2'd0) go = 1'b1;
        else if (mode_i == 2'd1) go = !acc_hit_i;
        else if (mode_i == 2'd2) go = !acc_hit_i || m_bits[line];
      end
      if (go) begin
        m_valid <= 1'b1;
        m_blk   <= (int'(acc_blk_i) + 1) % (1 << ADDR_W);
      end else if (m_valid && pf_ready_i) begin
        m_valid <= 1'b0;
      end
      if (acc_valid_i && acc_hit_i) m_bits[line] <= 1'b0;
      if (fill_valid_i) m_bits[int'(fill_line_i)] <= fill_is_pf_i;
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(pf_valid_o == m_valid, "R9 model valid", pf_valid_o, m_valid);
      if (m_valid) chk(pf_blk_o == ADDR_W'(m_blk), "R2 model block", pf_blk_o, m_blk);
      chk(tag_bits_o == LINES'(model_tags()), "R5 model tags", tag_bits_o, model_tags());
    end
  end

  // One clock: drive at negedge, return at the following negedge.
  task automatic cyc(input bit av, input int unsigned ab, input bit ah,
                     input bit fv, input int unsigned fl, input bit fp);
    acc_valid_i  = av;
    acc_blk_i    = ADDR_W'(ab);
    acc_hit_i    = ah;
    fill_valid_i = fv;
    fill_line_i  = LINE_W'(fl);
    fill_is_pf_i = fp;
    @(negedge clk);
    acc_valid_i  = 1'b0;
    fill_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_i = 2'd0; pf_ready_i = 1'b1;
    acc_valid_i = 0; acc_blk_i = 0; acc_hit_i = 0;
    fill_valid_i = 0; fill_line_i = 0; fill_is_pf_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_on = 1'b1;
    chk(pf_valid_o == 1'b0, "R1 valid after reset", pf_valid_o, 0);
    chk(tag_bits_o == '0, "R1 tags after reset", tag_bits_o, 0);

    // R2 lookahead on a hit
    mode_i = 2'd0;
    cyc(1, 12'h010, 1, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h011, "R2 lookahead hit", pf_blk_o, 12'h011);

    // R3 miss-only
    mode_i = 2'd1;
    cyc(1, 12'h020, 1, 0, 0, 0);
    chk(!pf_valid_o, "R3 hit no request", pf_valid_o, 0);
    cyc(1, 12'h020, 0, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h021, "R3 miss request", pf_blk_o, 12'h021);

    // R5 prefetch fill then R4 tagged first hit
    cyc(0, 0, 0, 1, 1, 1);
    chk(tag_bits_o[1] == 1'b1, "R5 prefetch fill sets", tag_bits_o[1], 1);
    mode_i = 2'd2;
    cyc(1, 12'h021, 1, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h022, "R4 tagged first hit", pf_blk_o, 12'h022);
    chk(tag_bits_o[1] == 1'b0, "R6 hit clears", tag_bits_o[1], 0);
    cyc(1, 12'h021, 1, 0, 0, 0);
    chk(!pf_valid_o, "R4 second hit silent", pf_valid_o, 0);
    cyc(1, 12'h030, 0, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h031, "R4 tagged miss", pf_blk_o, 12'h031);
    cyc(0, 0, 0, 1, 0, 0);
    chk(tag_bits_o[0] == 1'b0, "R5 demand fill clear", tag_bits_o[0], 0);

    // R8 overflow
    mode_i = 2'd0;
    cyc(1, 12'hFFF, 0, 0, 0, 0);
    chk(!pf_valid_o, "R8 top block", pf_valid_o, 0);

    // R7 off mode
    mode_i = 2'd3;
    cyc(1, 12'h044, 0, 1, 5, 1);
    chk(!pf_valid_o, "R7 off miss", pf_valid_o, 0);
    chk(tag_bits_o[5] == 1'b1, "R7 fill still works", tag_bits_o[5], 1);
    cyc(1, 12'h045, 1, 0, 0, 0);
    chk(!pf_valid_o && tag_bits_o[5] == 1'b0, "R7 hit clears, silent", tag_bits_o[5], 0);

    // R9 hold and replace
    mode_i = 2'd0; pf_ready_i = 1'b0;
    cyc(1, 12'h100, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h101, "R9 held while stalled", pf_blk_o, 12'h101);
    cyc(1, 12'h200, 0, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h201, "R9 replaced", pf_blk_o, 12'h201);
    pf_ready_i = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    chk(!pf_valid_o, "R9 emptied after handshake", pf_valid_o, 0);

    // R10 fill beats hit on same line
    mode_i = 2'd2;
    cyc(1, 12'h067, 1, 1, 7, 1);
    chk(!pf_valid_o, "R4 hit tag zero", pf_valid_o, 0);
    chk(tag_bits_o[7] == 1'b1, "R10 fill wins", tag_bits_o[7], 1);
    cyc(1, 12'h067, 1, 0, 0, 0);
    chk(pf_valid_o && pf_blk_o == 12'h068, "R4 stream step", pf_blk_o, 12'h068);

    // random run, compared against the model every cycle
    for (int n = 0; n < 2000; n++) begin
      int unsigned ab;
      mode_i     = 2'($urandom_range(0, 3));
      pf_ready_i = ($urandom_range(0, 3) != 0);
      ab = ($urandom_range(0, 15) == 0) ? 12'hFFF : $urandom_range(0, 40);
      cyc($urandom_range(0, 3) != 0, ab, $urandom_range(0, 1) == 1,
          $urandom_range(0, 2) == 0, $urandom_range(0, LINES - 1), $urandom_range(0, 1) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule